// File: doc/BRIEF.md
# Group-Priority Interrupt Controller with Serial Acknowledge Chains

This block arbitrates interrupt requests from a set of devices on behalf of a small processor core. The devices are split into priority groups. Group `g` sits at priority level `g+1`, so a higher group index means higher priority. Inside each group, the devices share one acknowledge, and that acknowledge passes from device to device in a chain. Device 0 of a group is nearest the core. A device takes the acknowledge only when it has a pending request, and in that case it blocks the acknowledge from every device after it. The controller keeps the current processor priority and a global interrupt-enable bit. It raises its request to the core only when the best pending group level is strictly above that priority.

The core answers an asserted `cpu_intr` with a one-cycle `cpu_inta`. On the next cycle the controller gives a one-cycle `cpu_ack` pulse, and in that same cycle it drives the winning device's 8-bit vector code and the new priority. The old priority goes onto a four-entry stack. A `cpu_reti` pulse pops the stack, restores the earlier level and turns interrupts back on. The vector output carries no back-pressure. The core must capture `ack_vec` and `ack_pri` in the cycle where `cpu_ack` is high, because the controller holds no offer open. Each device has its own enable bit, and it can be set to level-sensitive or rising-edge request mode.

Top module: `pic_daisy_ctrl`

## Requirements
- R1: `cpu_intr` is high exactly when `gie` is 1 and the highest level among groups with an effective pending request is strictly greater than `cur_pri`. A request at an equal or lower level does not raise `cpu_intr`.
- R2: When several groups are pending, the group with the highest index is acknowledged.
- R3: Within the acknowledged group, the pending device with the lowest index (device 0 is nearest the core) wins. Devices with higher indices receive no acknowledge.
- R4: An accept happens when `cpu_inta` is high while `cpu_intr` is high and `cpu_reti` is low. In the next cycle only, `cpu_ack` is 1, `ack_vec` holds the winner's code, and both `ack_pri` and `cur_pri` equal the winner's group level. Device `d` takes its code from bits `[8*d+7:8*d]` of `dev_vec`, where `d = group*DEV_PER_GRP + position`.
- R5: An accept clears `gie`. When no accept happens, a `gie_set` pulse sets `gie` to 1 on the next cycle.
- R6: A device in edge mode (`dev_edge` bit 1) latches a rising edge of its request. Its acknowledge clears the latch, so a request held high is serviced only once.
- R7: When a device's `dev_en` bit is 0, its request is ignored and cannot raise `cpu_intr`.
- R8: An accept pushes the old `cur_pri` onto a 4-entry stack. A `cpu_reti` pulse with a non-empty stack pops it into `cur_pri` and sets `gie`. A `cpu_reti` pulse with an empty stack changes nothing.
- R9: After reset, `cur_pri` is 0, `gie` is 0, the stack is empty, and `cpu_intr` and `cpu_ack` are 0.
- R10: A `cpu_inta` pulse while `cpu_intr` is low produces no `cpu_ack` and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | NUM_GRP*DEV_PER_GRP | Request line for each device |
| dev_en | input | NUM_GRP*DEV_PER_GRP | Local enable bit for each device |
| dev_edge | input | NUM_GRP*DEV_PER_GRP | 1 selects rising-edge mode for that device |
| dev_vec | input | NUM_GRP*DEV_PER_GRP*VEC_W | Vector code for each device |
| gie_set | input | 1 | Pulse that turns the global enable on |
| cpu_inta | input | 1 | Core acknowledge of `cpu_intr` |
| cpu_reti | input | 1 | Return-from-routine pulse |
| cpu_intr | output | 1 | Interrupt request to the core |
| cpu_ack | output | 1 | One-cycle pulse: vector and priority are valid |
| ack_vec | output | VEC_W | Vector code of the serviced device |
| ack_pri | output | PW | Priority level of the serviced group |
| cur_pri | output | PW | Current processor priority |
| gie | output | 1 | Global interrupt enable |

## Verification
A stale edge latch shows at the ports as a second `cpu_intr` after `cpu_reti` for a request that was already serviced. A corrupted stack entry shows as a wrong `cur_pri` in the cycle after a return, and then as `cpu_intr` being wrongly asserted or withheld. A broken chain or group pick shows as the wrong `ack_vec` in the one cycle where `cpu_ack` is high. A reference model compares every output on every clock, so any of these faults is caught in the first cycle where it reaches a pin.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int VEC_W_DEF = 8;

  function automatic int lvl_width(input int ngrp);
    return $clog2(ngrp + 1);
  endfunction
endpackage

// File: rtl/pic_group_chain.sv
module pic_group_chain #(
  parameter int ND    = 4,
  parameter int VEC_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ND-1:0]       req,
  input  logic [ND-1:0]       en,
  input  logic [ND-1:0]       edge_md,
  input  logic [ND*VEC_W-1:0] vec,
  input  logic                ack,
  output logic                grp_req,
  output logic [VEC_W-1:0]    win_vec
);
  logic [ND-1:0] req_q;
  logic [ND-1:0] lat_q;
  logic [ND-1:0] pend;
  logic [ND-1:0] take;
  logic [ND:0]   pass;

  // per-device request conditioning
  for (genvar k = 0; k < ND; k++) begin : g_dev
    logic rise;
    assign rise    = req[k] & ~req_q[k];
    assign pend[k] = en[k] & (edge_md[k] ? lat_q[k] : req[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[k] <= 1'b0;
        lat_q[k] <= 1'b0;
      end else begin
        req_q[k] <= req[k];
        lat_q[k] <= (lat_q[k] & ~(take[k] & ack)) | rise;
      end
    end
  end

  // serial acknowledge chain: position 0 is nearest the core
  assign pass[0] = 1'b1;
  for (genvar k = 0; k < ND; k++) begin : g_chain
    assign take[k]   = pass[k] & pend[k];
    assign pass[k+1] = pass[k] & ~pend[k];
  end

  always_comb begin
    win_vec = '0;
    for (int k = 0; k < ND; k++)
      if (take[k]) win_vec = vec[k*VEC_W +: VEC_W];
  end

  assign grp_req = |pend;

  // acknowledge only reaches a group that is requesting
  assert_ack_to_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> grp_req);
  // chain hands the acknowledge to at most one device
  assert_single_taker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take & pend));
endmodule

// File: rtl/pic_level_pick.sv
module pic_level_pick #(
  parameter int NG = 4,
  parameter int PW = 3,
  parameter int GW = 2
) (
  input  logic [NG-1:0] grp_req,
  output logic [PW-1:0] best_lvl,
  output logic [GW-1:0] best_idx
);
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_req[g]) begin
        best_lvl = PW'(g + 1);
        best_idx = GW'(g);
      end
    end
  end
endmodule

// File: rtl/pic_pri_stack.sv
module pic_pri_stack #(
  parameter int DEPTH = 4,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] top,
  output logic          empty,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign top   = empty ? '0 : mem[cnt - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && !full) begin
      mem[cnt] <= din;
      cnt      <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_mixed_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/pic_daisy_ctrl.sv
module pic_daisy_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_GRP     = 4,
  parameter int DEV_PER_GRP = 4,
  parameter int VEC_W       = VEC_W_DEF,
  parameter int STK_DEPTH   = 4,
  parameter int PW          = lvl_width(NUM_GRP)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_GRP*DEV_PER_GRP-1:0]       dev_req,
  input  logic [NUM_GRP*DEV_PER_GRP-1:0]       dev_en,
  input  logic [NUM_GRP*DEV_PER_GRP-1:0]       dev_edge,
  input  logic [NUM_GRP*DEV_PER_GRP*VEC_W-1:0] dev_vec,
  input  logic                                 gie_set,
  input  logic                                 cpu_inta,
  input  logic                                 cpu_reti,
  output logic                                 cpu_intr,
  output logic                                 cpu_ack,
  output logic [VEC_W-1:0]                     ack_vec,
  output logic [PW-1:0]                        ack_pri,
  output logic [PW-1:0]                        cur_pri,
  output logic                                 gie
);
  localparam int GW  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int GSZ = DEV_PER_GRP;

  logic [NUM_GRP-1:0] grp_req;
  logic [NUM_GRP-1:0] grp_ack;
  logic [VEC_W-1:0]   grp_vec [NUM_GRP];
  logic [PW-1:0]      best_lvl;
  logic [GW-1:0]      best_idx;
  logic [PW-1:0]      pri_q;
  logic               gie_q;
  logic               accept;
  logic               pop;
  logic [PW-1:0]      stk_top;
  logic               stk_empty;
  logic               stk_full;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_ack[g] = accept && (best_idx == GW'(g));
    pic_group_chain #(.ND(GSZ), .VEC_W(VEC_W)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (dev_req [g*GSZ +: GSZ]),
      .en      (dev_en  [g*GSZ +: GSZ]),
      .edge_md (dev_edge[g*GSZ +: GSZ]),
      .vec     (dev_vec [g*GSZ*VEC_W +: GSZ*VEC_W]),
      .ack     (grp_ack[g]),
      .grp_req (grp_req[g]),
      .win_vec (grp_vec[g])
    );
  end

  pic_level_pick #(.NG(NUM_GRP), .PW(PW), .GW(GW)) u_pick (
    .grp_req  (grp_req),
    .best_lvl (best_lvl),
    .best_idx (best_idx)
  );

  assign cpu_intr = gie_q && (best_lvl > pri_q);
  assign accept   = cpu_inta && cpu_intr && !cpu_reti;
  assign pop      = cpu_reti && !stk_empty;

  pic_pri_stack #(.DEPTH(STK_DEPTH), .PW(PW)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .pop   (pop),
    .din   (pri_q),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q   <= '0;
      gie_q   <= 1'b0;
      cpu_ack <= 1'b0;
      ack_vec <= '0;
      ack_pri <= '0;
    end else begin
      cpu_ack <= accept;
      if (accept) begin
        pri_q   <= best_lvl;
        gie_q   <= 1'b0;
        ack_vec <= grp_vec[best_idx];
        ack_pri <= best_lvl;
      end else if (pop) begin
        pri_q <= stk_top;
        gie_q <= 1'b1;
      end else if (gie_set) begin
        gie_q <= 1'b1;
      end
    end
  end

  assign cur_pri = pri_q;
  assign gie     = gie_q;

  assert_pri_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (ack_pri > $past(cur_pri)));
  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
  assert_ack_pri_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (cur_pri == ack_pri));
  assert_gie_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !gie);
  assert_pri_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !pop) |=> $stable(cur_pri));
  assert_no_stack_spill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !stk_full);
endmodule

// File: tb/pic_daisy_ctrl_bench.sv
module pic_daisy_ctrl_bench;
  localparam int CLK_PER = 10;
  localparam int NG = 4;
  localparam int ND = 4;
  localparam int NDEV = NG * ND;
  localparam int VW = 8;
  localparam int PW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [NDEV-1:0] dev_req = '0, dev_en = '1, dev_edge = '0;
  logic [NDEV*VW-1:0] dev_vec;
  logic gie_set = 0, cpu_inta = 0, cpu_reti = 0;
  logic cpu_intr, cpu_ack, gie;
  logic [VW-1:0] ack_vec;
  logic [PW-1:0] ack_pri, cur_pri;

  int checks = 0, errors = 0;
  int cyc_n = 0;

  // reference model state
  bit m_lat [NDEV];
  bit m_prev [NDEV];
  int m_stk [$];
  int m_pri = 0;
  bit m_gie = 0;
  bit m_ack = 0;
  int m_vec = 0;
  int m_apri = 0;

  always #(CLK_PER/2) clk = ~clk;

  pic_daisy_ctrl u_pic_daisy_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_en(dev_en),
    .dev_edge(dev_edge), .dev_vec(dev_vec), .gie_set(gie_set),
    .cpu_inta(cpu_inta), .cpu_reti(cpu_reti), .cpu_intr(cpu_intr),
    .cpu_ack(cpu_ack), .ack_vec(ack_vec), .ack_pri(ack_pri),
    .cur_pri(cur_pri), .gie(gie)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_vec
    assign dev_vec[d*VW +: VW] = VW'(8'h40 + d * 5);
  end

  function automatic int vec_of(input int d);
    return (8'h40 + d * 5) & 8'hFF;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc_n, act, exp);
    end
  endtask

  function automatic bit m_pend(input int d);
    return dev_en[d] && (dev_edge[d] ? m_lat[d] : dev_req[d]);
  endfunction

  function automatic int m_best();
    int b = 0;
    for (int d = 0; d < NDEV; d++) if (m_pend(d)) b = d / ND + 1;
    return b;
  endfunction

  function automatic bit m_intr();
    return m_gie && (m_best() > m_pri);
  endfunction

  task automatic m_step();
    bit acc;
    int b, w;
    bit rise [NDEV];
    acc = cpu_inta && m_intr() && !cpu_reti;
    b = m_best();
    w = -1;
    for (int d = 0; d < NDEV; d++) rise[d] = dev_req[d] && !m_prev[d];
    if (acc)
      for (int d = (b - 1) * ND; d < b * ND; d++)
        if (w < 0 && m_pend(d)) w = d;
    m_ack = acc;
    if (acc) begin
      m_vec = vec_of(w);
      m_apri = b;
      m_stk.push_back(m_pri);
      m_pri = b;
      m_gie = 0;
      m_lat[w] = 0;
    end else if (cpu_reti && m_stk.size() > 0) begin
      m_pri = m_stk.pop_back();
      m_gie = 1;
    end else if (gie_set) begin
      m_gie = 1;
    end
    for (int d = 0; d < NDEV; d++) begin
      if (rise[d]) m_lat[d] = 1;
      m_prev[d] = dev_req[d];
    end
  endtask

  // compare all outputs, advance one clock, update model
  task automatic tick();
    #1;
    chk("R1 cpu_intr", cpu_intr, m_intr());
    chk("R4 cpu_ack", cpu_ack, m_ack);
    if (m_ack) begin
      chk("R4 ack_vec", ack_vec, m_vec);
      chk("R4 ack_pri", ack_pri, m_apri);
    end
    chk("R8 cur_pri", cur_pri, m_pri);
    chk("R5 gie", gie, m_gie);
    @(posedge clk);
    m_step();
    cyc_n++;
    @(negedge clk);
    gie_set = 0; cpu_inta = 0; cpu_reti = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    for (int d = 0; d < NDEV; d++) begin m_lat[d] = 0; m_prev[d] = 0; end
    #(CLK_PER * 3);
    #1;
    chk("R9 reset intr", cpu_intr, 0);
    chk("R9 reset ack", cpu_ack, 0);
    chk("R9 reset pri", cur_pri, 0);
    chk("R9 reset gie", gie, 0);
    @(negedge clk);
    rst_n = 1;
    idle(2);

    // R5: request while global enable off stays quiet
    dev_req[1] = 1; dev_req[2] = 1;
    tick();
    chk("R5 intr held while gie off", cpu_intr, 0);
    gie_set = 1;
    tick();
    #1 chk("R1 intr level1 over 0", cpu_intr, 1);
    cpu_inta = 1;
    tick();
    // R3: device 1 nearer than device 2
    chk("R3 nearest device code", ack_vec, vec_of(1));
    chk("R4 ack pulse", cpu_ack, 1);
    chk("R5 gie cleared", gie, 0);
    idle(1);
    chk("R4 ack one cycle", cpu_ack, 0);

    // R1: equal level held off
    gie_set = 1;
    tick();
    #1 chk("R1 equal level held", cpu_intr, 0);
    dev_req[5] = 1;
    tick();
    cpu_inta = 1;
    tick();
    chk("R4 group1 code", ack_vec, vec_of(5));
    chk("R4 group1 pri", cur_pri, 2);

    // R2: groups 2 and 3 together, group 3 wins
    dev_req[9] = 1; dev_req[14] = 1; dev_req[12] = 0;
    gie_set = 1;
    tick();
    cpu_inta = 1;
    tick();
    chk("R2 highest group wins", ack_vec, vec_of(14));
    chk("R2 pri 4", ack_pri, 4);

    // R8: unwind the stack
    dev_req = '0;
    tick();
    cpu_reti = 1; tick();
    chk("R8 pop to 2", cur_pri, 2);
    chk("R8 pop sets gie", gie, 1);
    cpu_reti = 1; tick();
    cpu_reti = 1; tick();
    chk("R8 pop to 0", cur_pri, 0);
    cpu_reti = 1; tick();
    chk("R8 empty pop ignored", cur_pri, 0);

    // R10: acknowledge with no request
    cpu_inta = 1; tick();
    idle(1);
    chk("R10 no spurious ack", cpu_ack, 0);

    // R7: masked request
    dev_en[10] = 0; dev_req[10] = 1;
    tick();
    #1 chk("R7 masked request", cpu_intr, 0);
    dev_req[10] = 0; dev_en[10] = 1;

    // R6: edge mode, held high, serviced once
    dev_edge[6] = 1; dev_req[6] = 1;
    tick(); tick();
    #1 chk("R6 edge latched", cpu_intr, 1);
    cpu_inta = 1; tick();
    chk("R6 edge code", ack_vec, vec_of(6));
    idle(1);
    cpu_reti = 1; tick();
    idle(1);
    #1 chk("R6 held level not repeated", cpu_intr, 0);
    dev_req[6] = 0; tick();
    dev_req[6] = 1; tick();
    #1 chk("R6 new edge seen", cpu_intr, 1);
    cpu_inta = 1; tick();
    chk("R6 second service", ack_vec, vec_of(6));
    dev_req = '0;
    cpu_reti = 1; tick();

    // nest through all four levels with one device each
    dev_edge = '0;
    for (int g = 0; g < NG; g++) begin
      dev_req[g * ND + 3] = 1;
      gie_set = 1; tick();
      cpu_inta = 1; tick();
      chk("R3 last device wins alone", ack_vec, vec_of(g * ND + 3));
    end
    dev_req = '0;
    for (int g = 0; g < NG + 1; g++) begin
      cpu_reti = 1; tick();
    end
    chk("R8 full unwind", cur_pri, 0);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule